// File: doc/BRIEF.md
# Width-Converting Dual-Clock Packet FIFO

This block carries packets from a host on one clock to a consumer on an unrelated clock. The host writes 16-bit half-words. Each half-word lands first in an input staging register. A packer then joins each pair of half-words into one 32-bit word and stores it in a dual-clock memory. The consumer drains the memory one 32-bit word per accepted transfer. The two sides exchange their pointers as Gray code through two-flop synchronisers. Because of those synchronisers, the full flag and the readable count are both conservative.

The host builds a packet as a start mark, then packed payload, then an end mark. The block treats all of these as ordinary half-words. Reading does not begin on the empty flag. It begins when the readable word count reaches a threshold that the consumer side programs, and it then runs until the memory is empty. When the write side sees that a read sequence has drained everything, it sets a sticky interrupt. The interrupt asks the host for the next packet and stays set until the host acknowledges it.

Back-pressure on both streams follows the valid/ready rules. A transfer happens on a clock edge where valid and ready are both high. A source that has raised valid keeps it and its data until that transfer. `s_ready` is high whenever the staging register is free, or is being emptied in the same cycle. `m_valid` never drops, and `m_data` never changes, while a word is waiting for `m_ready`.

Top module: `pkt_fifo_w16r32`

## Requirements
- R1: Each pair of accepted half-words forms one 32-bit read word: the first-accepted half-word is in bits 15:0 and the second is in bits 31:16.
- R2: Read words come out in write order with their contents intact, including across pointer wrap-around. A word waiting with `m_ready` low stays valid and unchanged.
- R3: No half-word is ever lost or overwritten. With the memory full, a pending low half held in the packer and one held in staging, `s_ready` is low. At that point exactly 2*DEPTH+2 half-words have been accepted and `rd_count` equals DEPTH.
- R4: `rd_count` gives the number of 32-bit words readable in the read domain. It never exceeds DEPTH.
- R5: While the FIFO is idle, `m_valid` stays low until `rd_count` reaches `rd_thresh`. A threshold of 0 counts as 1.
- R6: Once a read sequence has started, `m_valid` stays high for as long as words remain, even when `rd_count` falls below the threshold.
- R7: After reset, `rd_empty` is 1, `m_valid` is 0, `s_ready` is 1, `irq` is 0 and `rd_count` is 0. Also, `m_valid` is never high while `rd_empty` is high.
- R8: `irq` is set when the write side sees the FIFO go from holding words to drained. It then stays set until an `irq_ack` pulse clears it.
- R9: When a drain event and `irq_ack` fall in the same write-clock cycle, the set wins. With `irq_ack` held high across a drain, `irq` is high for exactly one write-clock cycle.
- R10: A lone half-word without its partner is not readable: `rd_count` stays 0 until the second half arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low |
| s_valid | input | 1 | Host half-word valid |
| s_ready | output | 1 | Staging register can accept |
| s_data | input | 16 | Host half-word |
| irq | output | 1 | Sticky drained interrupt (write domain) |
| irq_ack | input | 1 | Clears irq (write domain) |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low |
| rd_thresh | input | PW | Word count that starts a read sequence |
| rd_count | output | PW | Readable 32-bit words |
| rd_empty | output | 1 | No readable word |
| m_valid | output | 1 | Read word valid |
| m_ready | input | 1 | Consumer accepts word |
| m_data | output | 32 | Read word |

## Verification
Two events can land in the same write-clock edge: the drain event that sets the interrupt, and the host acknowledge that clears it. The bench provokes this by holding `irq_ack` high for the whole time it drains a one-word packet. The drain event therefore meets an active acknowledge on the edge where it fires. A monitor counts the write-clock cycles in which `irq` is high during that window. Exactly one is expected, because the set takes priority and the acknowledge clears the bit on the following edge.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/pkt_fifo_sync2.sv
module pkt_fifo_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pkt_fifo_wside.sv
module pkt_fifo_wside
  import pkt_fifo_pkg::*;
#(
  parameter int AW = 3,
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  half_t         s_data,
  input  logic [PW-1:0] rgray_sync,
  output logic [PW-1:0] wgray,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output word_t         mem_wdata,
  output logic          full,
  output logic          drained
);
  logic          stage_v, lo_v, stage_pop, wempty, wempty_q;
  half_t         stage_d, lo_d;
  logic [PW-1:0] wbin, wbin_nx;

  // conservative full: compare against the synchronised (stale) read pointer
  assign full      = (wgray == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});
  assign stage_pop = stage_v && (!lo_v || !full);
  assign s_ready   = !stage_v || stage_pop;
  assign mem_we    = stage_pop && lo_v;
  assign mem_waddr = wbin[AW-1:0];
  assign mem_wdata = {stage_d, lo_d};
  assign wbin_nx   = wbin + {{(PW-1){1'b0}}, mem_we};
  assign wempty    = (wgray == rgray_sync);
  assign drained   = wempty && !wempty_q;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      stage_v  <= 1'b0;
      stage_d  <= '0;
      lo_v     <= 1'b0;
      lo_d     <= '0;
      wbin     <= '0;
      wgray    <= '0;
      wempty_q <= 1'b1;
    end else begin
      if (s_valid && s_ready) begin
        stage_v <= 1'b1;
        stage_d <= s_data;
      end else if (stage_pop) begin
        stage_v <= 1'b0;
      end
      if (stage_pop) begin
        if (lo_v) begin
          lo_v <= 1'b0;
        end else begin
          lo_v <= 1'b1;
          lo_d <= stage_d;
        end
      end
      wbin     <= wbin_nx;
      wgray    <= wbin_nx ^ (wbin_nx >> 1);
      wempty_q <= wempty;
    end
  end
endmodule

// File: rtl/pkt_fifo_rside.sv
module pkt_fifo_rside #(
  parameter int AW = 3,
  localparam int PW = AW + 1
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic [PW-1:0] wgray_sync,
  input  logic [PW-1:0] rd_thresh,
  input  logic          m_ready,
  output logic          m_valid,
  output logic [PW-1:0] rd_count,
  output logic          rd_empty,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] mem_raddr
);
  logic [PW-1:0] rbin, rbin_nx, wbin_seen, thr_eff;
  logic          armed, pop;

  always_comb begin
    wbin_seen[PW-1] = wgray_sync[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      wbin_seen[i] = wbin_seen[i+1] ^ wgray_sync[i];
    end
  end

  assign rd_count  = wbin_seen - rbin;
  assign rd_empty  = (rd_count == '0);
  assign thr_eff   = (rd_thresh == '0) ? {{(PW-1){1'b0}}, 1'b1} : rd_thresh;
  assign m_valid   = armed && !rd_empty;
  assign pop       = m_valid && m_ready;
  assign rbin_nx   = rbin + {{(PW-1){1'b0}}, pop};
  assign mem_raddr = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      armed <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      if (!armed && rd_count >= thr_eff) begin
        armed <= 1'b1;
      end else if (pop && rd_count == {{(PW-1){1'b0}}, 1'b1}) begin
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pkt_fifo_w16r32.sv
module pkt_fifo_w16r32
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [15:0]   s_data,
  output logic          irq,
  input  logic          irq_ack,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic [PW-1:0] rd_thresh,
  output logic [PW-1:0] rd_count,
  output logic          rd_empty,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [31:0]   m_data
);
  word_t         mem [DEPTH];
  logic [PW-1:0] wgray, rgray, wgray_r, rgray_w;
  logic          mem_we, w_full, drained;
  logic [AW-1:0] waddr, raddr;
  word_t         wdata;

  pkt_fifo_sync2 #(.W(PW)) u_sync_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
  pkt_fifo_sync2 #(.W(PW)) u_sync_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

  pkt_fifo_wside #(.AW(AW)) u_wside (
    .wclk(wclk), .wrst_n(wrst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .rgray_sync(rgray_w), .wgray(wgray), .mem_we(mem_we), .mem_waddr(waddr),
    .mem_wdata(wdata), .full(w_full), .drained(drained)
  );

  pkt_fifo_rside #(.AW(AW)) u_rside (
    .rclk(rclk), .rrst_n(rrst_n), .wgray_sync(wgray_r), .rd_thresh(rd_thresh),
    .m_ready(m_ready), .m_valid(m_valid), .rd_count(rd_count), .rd_empty(rd_empty),
    .rgray(rgray), .mem_raddr(raddr)
  );

  always_ff @(posedge wclk) begin
    if (mem_we) mem[waddr] <= wdata;
  end
  assign m_data = mem[raddr];

  // drain sets, acknowledge clears; set has priority
  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) irq <= 1'b0;
    else         irq <= drained | (irq & ~irq_ack);
  end
endmodule

// File: rtl/pkt_fifo_chk.sv
module pkt_fifo_chk #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          mem_we,
  input logic          w_full,
  input logic          irq,
  input logic          irq_ack,
  input logic          m_valid,
  input logic          m_ready,
  input logic [31:0]   m_data,
  input logic          rd_empty,
  input logic [PW-1:0] rd_count,
  input logic [PW-1:0] rd_thresh
);
  logic [PW-1:0] thr_eff;
  assign thr_eff = (rd_thresh == '0) ? {{(PW-1){1'b0}}, 1'b1} : rd_thresh;

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    mem_we |-> !w_full);
  assert_hold_word_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  assert_count_bound_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_count <= PW'(DEPTH));
  assert_start_gate_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(m_valid) |-> (rd_count >= thr_eff));
  assert_empty_idle_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_empty |-> !m_valid);
  assert_irq_sticky_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
    (irq && !irq_ack) |=> irq);
endmodule

bind pkt_fifo_w16r32 pkt_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .mem_we(mem_we), .w_full(w_full), .irq(irq), .irq_ack(irq_ack),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .rd_empty(rd_empty), .rd_count(rd_count), .rd_thresh(rd_thresh)
);

// File: tb/test_pkt_fifo_w16r32.sv
module test_pkt_fifo_w16r32;
  localparam int DEPTH = 8;
  localparam int PW = $clog2(DEPTH) + 1;

  logic          wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic          s_valid = 0, s_ready, irq, irq_ack = 0, rd_empty, m_valid, m_ready = 0;
  logic [15:0]   s_data = '0;
  logic [PW-1:0] rd_thresh = '0, rd_count;
  logic [31:0]   m_data;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] expq[$];
  logic [15:0] pend_lo;
  bit          pend_v = 0;
  bit          mon_en = 0;
  int          mon_cnt = 0;

  always #10 wclk = ~wclk;
  always #15 rclk = ~rclk;

  pkt_fifo_w16r32 #(.DEPTH(DEPTH)) i_pkt_fifo_w16r32 (
    .wclk(wclk), .wrst_n(wrst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .irq(irq), .irq_ack(irq_ack), .rclk(rclk), .rrst_n(rrst_n), .rd_thresh(rd_thresh),
    .rd_count(rd_count), .rd_empty(rd_empty), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data)
  );

  always @(negedge wclk) if (mon_en && irq) mon_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d, input int tmo, output bit ok);
    @(negedge wclk);
    s_valid = 1; s_data = d; ok = 0;
    for (int i = 0; i < tmo; i++) begin
      if (s_ready) begin ok = 1; break; end
      @(negedge wclk);
    end
    if (ok) begin
      @(posedge wclk);
      @(negedge wclk);
      if (pend_v) begin expq.push_back({d, pend_lo}); pend_v = 0; end
      else begin pend_lo = d; pend_v = 1; end
    end
    s_valid = 0;
  endtask

  task automatic push_n(input logic [15:0] base, input int n);
    bit ok;
    for (int i = 0; i < n; i++) push(base + 16'(i), 40, ok);
  endtask

  task automatic pop_word(input string req);
    logic [31:0] e;
    int w = 0;
    @(negedge rclk);
    while (!m_valid && w < 60) begin @(negedge rclk); w++; end
    e = (expq.size() > 0) ? expq.pop_front() : 32'hDEAD_BEEF;
    check(req, m_data, e);
    m_ready = 1;
    @(posedge rclk);
    @(negedge rclk);
    m_ready = 0;
  endtask

  task automatic wait_w(input int n); repeat (n) @(negedge wclk); endtask
  task automatic wait_r(input int n); repeat (n) @(negedge rclk); endtask

  task automatic ack_irq;
    @(negedge wclk); irq_ack = 1;
    @(negedge wclk); irq_ack = 0;
    check("R8 irq cleared by ack", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_reset;
    check("R7 rd_empty", {31'b0, rd_empty}, 32'd1);
    check("R7 m_valid", {31'b0, m_valid}, 32'd0);
    check("R7 s_ready", {31'b0, s_ready}, 32'd1);
    check("R7 irq", {31'b0, irq}, 32'd0);
    check("R7 rd_count", 32'(rd_count), 32'd0);
  endtask

  task automatic t_threshold;
    rd_thresh = PW'(4);
    push_n(16'hA000, 6);
    wait_r(20);
    check("R4 count three words", 32'(rd_count), 32'd3);
    check("R5 held below threshold", {31'b0, m_valid}, 32'd0);
    push_n(16'hA006, 2);
    wait_r(20);
    check("R4 count four words", 32'(rd_count), 32'd4);
    check("R5 starts at threshold", {31'b0, m_valid}, 32'd1);
    check("R8 no irq before drain", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_drain;
    check("R1 packing low first", m_data, 32'hA001_A000);
    pop_word("R1 first word");
    check("R6 continues below threshold", {31'b0, m_valid}, 32'd1);
    for (int i = 0; i < 3; i++) pop_word("R2 order");
    wait_r(4);
    check("R7 empty after drain", {31'b0, rd_empty}, 32'd1);
    check("R7 no valid when empty", {31'b0, m_valid}, 32'd0);
    wait_w(12);
    check("R8 irq set on drain", {31'b0, irq}, 32'd1);
    wait_w(12);
    check("R8 irq sticky", {31'b0, irq}, 32'd1);
    ack_irq();
  endtask

  task automatic t_lone_half;
    bit ok;
    rd_thresh = '0;
    push(16'h5A5A, 40, ok);
    wait_r(20);
    check("R10 lone half not counted", 32'(rd_count), 32'd0);
    check("R10 lone half not valid", {31'b0, m_valid}, 32'd0);
    push(16'hC3C3, 40, ok);
    wait_r(20);
    check("R10 pair counted", 32'(rd_count), 32'd1);
    pop_word("R1 pair packing");
    wait_w(12);
    check("R8 irq after single word", {31'b0, irq}, 32'd1);
    ack_irq();
  endtask

  task automatic t_full;
    bit ok;
    int acc = 0;
    rd_thresh = PW'(DEPTH);
    for (int i = 0; i < 2 * DEPTH + 3; i++) begin
      push(16'h3000 + 16'(i), 30, ok);
      if (!ok) break;
      acc++;
    end
    check("R3 accepted halves at full", 32'(acc), 32'(2 * DEPTH + 2));
    check("R3 s_ready low at full", {31'b0, s_ready}, 32'd0);
    wait_r(10);
    check("R4 count at full", 32'(rd_count), 32'(DEPTH));
    rd_thresh = PW'(1);
    for (int i = 0; i < DEPTH + 1; i++) pop_word("R2 wrap order");
    wait_w(12);
    ack_irq();
  endtask

  task automatic t_collide;
    rd_thresh = PW'(1);
    @(negedge wclk); irq_ack = 1;
    mon_cnt = 0; mon_en = 1;
    push_n(16'h7700, 2);
    pop_word("R9 word");
    wait_w(20);
    mon_en = 0;
    check("R9 set beats ack", 32'(mon_cnt), 32'd1);
    @(negedge wclk); irq_ack = 0;
    check("R9 irq low after", {31'b0, irq}, 32'd0);
  endtask

  initial begin
    #5;
    check("R7 irq before release", {31'b0, irq}, 32'd0);
    #100;
    wrst_n = 1; rrst_n = 1;
    wait_w(3);
    t_reset();
    t_threshold();
    t_drain();
    t_lone_half();
    t_full();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule